// File: doc/BRIEF.md
# EPROM Fast-Programming Sequencer

This block drives the pins of a parallel UV-erasable EPROM so that a range of bytes can be written with the adaptive pulse method. It raises the supply select and then the programming voltage enable. It walks the address range upward. For each address it asks a data source for the target byte, applies fixed one-millisecond chip-enable pulses, and reads the byte back after every pulse. Pulses stop when the read-back matches the target. One overprogram pulse then follows, and its length is a fixed multiple of the number of short pulses that were needed.

A byte that still does not match after the retry cap ends the run with a fail result. Both supplies are lowered first, with the programming voltage removed before the supply select. After the last address the supplies return to normal levels. The range is then read again in plain read mode and compared against a second request of each target byte. All intervals are counted in clock cycles and derived from a clock-frequency parameter, so the short pulse is exact to one clock.

Top module: `prog_seq`

## Requirements
- R1: After reset and while idle, the chip-enable and output-enable are high (inactive), the data driver is off, the programming voltage enable and the raised-supply select are 0, and busy, done and fail are 0.
- R2: Each short program pulse holds dev_ce_n low for exactly CLK_HZ/1000 cycles, with the programming voltage enabled.
- R3: After every short pulse a verify read is made with dev_ce_n high, dev_oe_n low and the programming voltage on. Short pulses for one address repeat until the read-back equals the target byte, so a cell that needs k pulses receives exactly k.
- R4: Once verify passes after n short pulses, exactly one overprogram pulse of OVER_MULT × n × (CLK_HZ/1000) cycles is applied. A target of all ones passes after the first pulse.
- R5: If the read-back still differs after MAX_TRIES short pulses, no overprogram pulse is applied and the run ends with fail = 1. fail_addr then holds that address and fail_data the last byte read back. Bits that are already 0 in the device but 1 in the target lead to this result.
- R6: The programming voltage enable is only ever 1 while the raised-supply select is 1. It rises after the select and falls before it, on the fail path too. When done or fail is shown, both are 0.
- R7: Address, data and programming voltage are stable for at least SETUP_NS before chip enable falls. Data is driven for at least SETUP_NS after chip enable rises. At least SETUP_NS pass between the release of the data driver and output enable falling, and the data driver is never on while output enable is low.
- R8: The device address changes only while dev_oe_n is high and was high in the previous cycle.
- R9: After the last address, the whole range is read with dev_ce_n and dev_oe_n low, the programming voltage off and the supply at normal level. Each byte is compared against the re-requested target, and the first mismatch ends the run with fail = 1, fail_addr and fail_data.
- R10: Addresses are processed in ascending order from first_addr to last_addr. Each address gets exactly one data request per pass, so two in a run that passes. A passing run ends with done = 1 and busy = 0.
- R11: A range with first_addr equal to last_addr programs and checks that single address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a run when idle, done or failed |
| first_addr | input | ADDR_W | First address of the range |
| last_addr | input | ADDR_W | Last address of the range (not below first_addr) |
| src_req | output | 1 | Request for the target byte of src_addr |
| src_addr | output | ADDR_W | Address whose target byte is requested |
| src_vld | input | 1 | Target byte is valid; accepted while src_req is high |
| src_byte | input | DATA_W | Target byte |
| dev_addr | output | ADDR_W | Device address lines |
| dev_wdata | output | DATA_W | Byte driven onto the device data bus |
| dev_wdata_oe | output | 1 | Enables the data bus driver |
| dev_rdata | input | DATA_W | Byte read from the device data bus |
| dev_ce_n | output | 1 | Device chip enable, active low (program pulse) |
| dev_oe_n | output | 1 | Device output enable, active low |
| dev_vpp_on | output | 1 | Programming voltage enable |
| dev_vcc_prog | output | 1 | Supply select: 1 raised programming level, 0 normal |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run passed |
| fail | output | 1 | The last run failed |
| fail_addr | output | ADDR_W | Address of the failing byte |
| fail_data | output | DATA_W | Byte read back at the failing address |

## Verification
Each state lasts a fixed number of cycles: the setup wait is SETUP_NS rounded up to whole clocks, the pulse is CLK_HZ/1000 clocks, and the read wait is the access time rounded up plus one clock. The read-back byte is registered in the last cycle of the read wait and compared in the following cycle. The bench device model therefore counts chip-enable low cycles at each falling clock edge and changes its stored cell only when a pulse ends, well before the next read. Setup, hold and release intervals are measured in falling-edge samples between events and compared with the rounded cycle counts. Result outputs are checked only after done or fail has risen, when every latched value has settled.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;

   typedef enum logic [4:0] {
      S_IDLE, S_VCC_UP, S_VPP_UP, S_FETCH, S_PSET, S_PULSE, S_PHOLD,
      S_PREL, S_PVER, S_PJUDGE, S_OSET, S_OPULSE, S_OHOLD, S_OREL,
      S_VPP_DN, S_VCC_DN, S_CFETCH, S_CREAD, S_CJUDGE, S_DONE, S_FAIL
   } seq_state_t;

   // nanoseconds to whole clock cycles, rounded up, never below one
   function automatic int unsigned ns_to_cyc(longint unsigned hz, longint unsigned ns);
      longint unsigned c;
      c = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
      if (c == 0) c = 1;
      return int'(c);
   endfunction

endpackage

// File: rtl/prog_seq_timer.sv
module prog_seq_timer #(
   parameter int TW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          last
);
   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt_q <= '0;
      else if (load)       cnt_q <= load_val;
      else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
   end

   // a state entered with load_val = N ends in its N-th cycle
   assign last = (cnt_q <= 1);
endmodule

// File: rtl/prog_seq_tries.sv
module prog_seq_tries #(
   parameter int MAX_TRIES = 25,
   parameter int STEP_CYC  = 3000,
   parameter int TW        = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          inc,
   output logic          at_cap,
   output logic [TW-1:0] over_cyc
);
   localparam int NW = $clog2(MAX_TRIES + 1);

   logic [NW-1:0] n_q;

   always_ff @(posedge clk) begin
      if (!rst_n)   n_q <= NW'(1);
      else if (clr) n_q <= NW'(1);
      else if (inc) n_q <= n_q + 1'b1;
   end

   assign at_cap   = (n_q == NW'(MAX_TRIES));
   assign over_cyc = TW'(n_q) * TW'(STEP_CYC);
endmodule

// File: rtl/prog_seq.sv
module prog_seq
   import prog_seq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 15,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned CLK_HZ    = 100_000_000,
   parameter int unsigned SETUP_NS  = 2000,
   parameter int unsigned ACCESS_NS = 150,
   parameter int unsigned MAX_TRIES = 25,
   parameter int unsigned OVER_MULT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] first_addr,
   input  logic [ADDR_W-1:0] last_addr,
   output logic              src_req,
   output logic [ADDR_W-1:0] src_addr,
   input  logic              src_vld,
   input  logic [DATA_W-1:0] src_byte,
   output logic [ADDR_W-1:0] dev_addr,
   output logic [DATA_W-1:0] dev_wdata,
   output logic              dev_wdata_oe,
   input  logic [DATA_W-1:0] dev_rdata,
   output logic              dev_ce_n,
   output logic              dev_oe_n,
   output logic              dev_vpp_on,
   output logic              dev_vcc_prog,
   output logic              busy,
   output logic              done,
   output logic              fail,
   output logic [ADDR_W-1:0] fail_addr,
   output logic [DATA_W-1:0] fail_data
);
   localparam int unsigned TICK_CYC  = CLK_HZ / 1000;
   localparam int unsigned SETUP_CYC = ns_to_cyc(CLK_HZ, SETUP_NS);
   localparam int unsigned VRD_CYC   = ns_to_cyc(CLK_HZ, ACCESS_NS) + 1;
   localparam int unsigned STEP_CYC  = OVER_MULT * TICK_CYC;
   localparam int          TW        = 32;

   if (TICK_CYC < 1) begin : g_bad_clk
      $error("prog_seq: CLK_HZ below 1 kHz gives no pulse tick");
   end
   if (MAX_TRIES < 1 || OVER_MULT < 1) begin : g_bad_cnt
      $error("prog_seq: MAX_TRIES and OVER_MULT must be at least 1");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_w
      $error("prog_seq: zero width");
   end

   seq_state_t        st_q, st_d;
   logic              t_end, t_load;
   logic [TW-1:0]     t_val, over_cyc;
   logic              tries_cap, tries_clr, tries_inc;
   logic [ADDR_W-1:0] addr_q, first_q, last_q;
   logic [DATA_W-1:0] tgt_q, rd_q;
   logic              fail_q, byte_ok, at_last;

   assign byte_ok = (rd_q == tgt_q);
   assign at_last = (addr_q == last_q);

   prog_seq_timer #(.TW(TW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .last(t_end));

   prog_seq_tries #(.MAX_TRIES(MAX_TRIES), .STEP_CYC(STEP_CYC), .TW(TW)) u_tries (
      .clk(clk), .rst_n(rst_n), .clr(tries_clr), .inc(tries_inc),
      .at_cap(tries_cap), .over_cyc(over_cyc));

   assign tries_clr = (st_q == S_FETCH) && src_vld;
   assign tries_inc = (st_q == S_PJUDGE) && !byte_ok && !tries_cap;

   // next state
   always_comb begin
      st_d = st_q;
      unique case (st_q)
         S_IDLE, S_DONE, S_FAIL: if (start) st_d = S_VCC_UP;
         S_VCC_UP: if (t_end) st_d = S_VPP_UP;
         S_VPP_UP: if (t_end) st_d = S_FETCH;
         S_FETCH:  if (src_vld) st_d = S_PSET;
         S_PSET:   if (t_end) st_d = S_PULSE;
         S_PULSE:  if (t_end) st_d = S_PHOLD;
         S_PHOLD:  if (t_end) st_d = S_PREL;
         S_PREL:   if (t_end) st_d = S_PVER;
         S_PVER:   if (t_end) st_d = S_PJUDGE;
         S_PJUDGE: st_d = byte_ok ? S_OSET : (tries_cap ? S_VPP_DN : S_PSET);
         S_OSET:   if (t_end) st_d = S_OPULSE;
         S_OPULSE: if (t_end) st_d = S_OHOLD;
         S_OHOLD:  if (t_end) st_d = S_OREL;
         S_OREL:   if (t_end) st_d = at_last ? S_VPP_DN : S_FETCH;
         S_VPP_DN: if (t_end) st_d = S_VCC_DN;
         S_VCC_DN: if (t_end) st_d = fail_q ? S_FAIL : S_CFETCH;
         S_CFETCH: if (src_vld) st_d = S_CREAD;
         S_CREAD:  if (t_end) st_d = S_CJUDGE;
         S_CJUDGE: st_d = !byte_ok ? S_FAIL : (at_last ? S_DONE : S_CFETCH);
         default:  st_d = S_IDLE;
      endcase
   end

   // duration of the state being entered
   assign t_load = (st_d != st_q);
   always_comb begin
      unique case (st_d)
         S_PULSE:           t_val = TW'(TICK_CYC);
         S_OPULSE:          t_val = over_cyc;
         S_PVER, S_CREAD:   t_val = TW'(VRD_CYC);
         S_VCC_UP, S_VPP_UP, S_PSET, S_PHOLD, S_PREL, S_OSET, S_OHOLD,
         S_OREL, S_VPP_DN, S_VCC_DN: t_val = TW'(SETUP_CYC);
         default:           t_val = TW'(1);
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= S_IDLE;
         addr_q    <= '0;
         first_q   <= '0;
         last_q    <= '0;
         tgt_q     <= '0;
         rd_q      <= '0;
         fail_q    <= 1'b0;
         fail_addr <= '0;
         fail_data <= '0;
      end else begin
         st_q <= st_d;
         unique case (st_q)
            S_IDLE, S_DONE, S_FAIL: if (start) begin
               first_q   <= first_addr;
               last_q    <= last_addr;
               addr_q    <= first_addr;
               fail_q    <= 1'b0;
               fail_addr <= '0;
               fail_data <= '0;
            end
            S_FETCH, S_CFETCH: if (src_vld) tgt_q <= src_byte;
            S_PVER, S_CREAD:   if (t_end) rd_q <= dev_rdata;
            S_PJUDGE: if (!byte_ok && tries_cap) begin
               fail_q    <= 1'b1;
               fail_addr <= addr_q;
               fail_data <= rd_q;
            end
            S_OREL: if (t_end) addr_q <= at_last ? first_q : addr_q + 1'b1;
            S_CJUDGE: begin
               if (!byte_ok) begin
                  fail_addr <= addr_q;
                  fail_data <= rd_q;
               end else if (!at_last) begin
                  addr_q <= addr_q + 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   // pin levels per state
   always_comb begin
      dev_ce_n     = 1'b1;
      dev_oe_n     = 1'b1;
      dev_wdata_oe = 1'b0;
      dev_vpp_on   = 1'b0;
      dev_vcc_prog = 1'b0;
      src_req      = 1'b0;
      unique case (st_q)
         S_VCC_UP, S_VPP_DN:  dev_vcc_prog = 1'b1;
         S_VPP_UP, S_FETCH, S_PJUDGE: begin
            dev_vcc_prog = 1'b1;
            dev_vpp_on   = 1'b1;
            src_req      = (st_q == S_FETCH);
         end
         S_PSET, S_PHOLD, S_OSET, S_OHOLD: begin
            dev_vcc_prog = 1'b1;
            dev_vpp_on   = 1'b1;
            dev_wdata_oe = 1'b1;
         end
         S_PULSE, S_OPULSE: begin
            dev_vcc_prog = 1'b1;
            dev_vpp_on   = 1'b1;
            dev_wdata_oe = 1'b1;
            dev_ce_n     = 1'b0;
         end
         S_PREL, S_OREL: begin
            dev_vcc_prog = 1'b1;
            dev_vpp_on   = 1'b1;
         end
         S_PVER: begin
            dev_vcc_prog = 1'b1;
            dev_vpp_on   = 1'b1;
            dev_oe_n     = 1'b0;
         end
         S_CFETCH: src_req = 1'b1;
         S_CREAD: begin
            dev_ce_n = 1'b0;
            dev_oe_n = 1'b0;
         end
         default: ;
      endcase
   end

   assign src_addr  = addr_q;
   assign dev_addr  = addr_q;
   assign dev_wdata = tgt_q;
   assign busy      = !(st_q inside {S_IDLE, S_DONE, S_FAIL});
   assign done      = (st_q == S_DONE);
   assign fail      = (st_q == S_FAIL);
endmodule

// File: rtl/prog_seq_chk.sv
module prog_seq_chk #(
   parameter int unsigned ADDR_W    = 15,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned TICK_CYC  = 100_000,
   parameter int unsigned SETUP_CYC = 200,
   parameter int unsigned STEP_CYC  = 300_000,
   parameter int unsigned MAX_TRIES = 25
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] dev_addr,
   input logic [DATA_W-1:0] dev_wdata,
   input logic              dev_wdata_oe,
   input logic              dev_ce_n,
   input logic              dev_oe_n,
   input logic              dev_vpp_on,
   input logic              dev_vcc_prog,
   input logic              busy,
   input logic              done,
   input logic              fail
);
   logic [ADDR_W+DATA_W:0] prev_q;
   logic [31:0]            stab_q, low_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '0;
         stab_q <= '0;
         low_q  <= '0;
      end else begin
         prev_q <= {dev_addr, dev_wdata, dev_vpp_on};
         stab_q <= ({dev_addr, dev_wdata, dev_vpp_on} != prev_q) ? 32'd0 : stab_q + 1;
         low_q  <= dev_ce_n ? 32'd0 : low_q + 1;
      end
   end

   assert_vpp_under_vcc_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dev_vpp_on |-> dev_vcc_prog);

   assert_rest_safe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done || fail) |-> (!dev_vpp_on && !dev_vcc_prog && dev_ce_n && dev_oe_n));

   assert_no_bus_fight_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !dev_oe_n |-> !dev_wdata_oe);

   assert_setup_before_ce_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(dev_ce_n) && dev_vpp_on) |-> (stab_q >= SETUP_CYC - 1));

   assert_pulse_width_R2_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(dev_ce_n) && dev_vpp_on) |->
         (low_q == TICK_CYC) || ((low_q % STEP_CYC) == 0 && low_q <= STEP_CYC * MAX_TRIES));

   assert_verify_ce_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!dev_oe_n && dev_vpp_on) |-> dev_ce_n);

   assert_addr_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dev_addr) |-> (dev_oe_n && $past(dev_oe_n)));

   assert_read_levels_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!dev_ce_n && !dev_oe_n) |-> (!dev_vpp_on && !dev_vcc_prog));

   assert_result_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && (busy || fail)));
endmodule

bind prog_seq prog_seq_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TICK_CYC(TICK_CYC), .SETUP_CYC(SETUP_CYC),
   .STEP_CYC(STEP_CYC), .MAX_TRIES(MAX_TRIES)
) u_chk (.*);

// File: tb/prog_seq_tb.sv
module prog_seq_tb;
   localparam int AW   = 4;
   localparam int DW   = 8;
   localparam int HZ   = 20_000;
   localparam int TICK = HZ / 1000;       // 20 cycles
   localparam int SETC = 3;               // 150 us at 20 kHz
   localparam int LIM  = 20_000;

   logic          clk = 0, rst_n = 0, start = 0;
   logic [AW-1:0] first_addr = '0, last_addr = '0;
   logic          src_req, src_vld = 0;
   logic [AW-1:0] src_addr;
   logic [DW-1:0] src_byte = '0;
   logic [AW-1:0] dev_addr;
   logic [DW-1:0] dev_wdata, dev_rdata;
   logic          dev_wdata_oe, dev_ce_n, dev_oe_n, dev_vpp_on, dev_vcc_prog;
   logic          busy, done, fail;
   logic [AW-1:0] fail_addr;
   logic [DW-1:0] fail_data;

   prog_seq #(.ADDR_W(AW), .DATA_W(DW), .CLK_HZ(HZ), .SETUP_NS(150_000),
              .ACCESS_NS(150), .MAX_TRIES(25), .OVER_MULT(3)) u_dut (.*);

   initial forever #5 clk = ~clk;

   // device and data-source model state
   logic [DW-1:0] mem [16];
   logic [DW-1:0] tgt [16];
   int need [16], icnt [16], olen [16], reqs [16];
   int low_len, stab, hold_c, rel_c;
   int min_setup = 1000, min_hold = 1000, min_rel = 1000;
   int v6 = 0, v8 = 0;
   logic corrupt_en = 0;
   logic [AW-1:0] corrupt_a = '0;
   int n_run = 0, n_fail = 0;

   always_comb dev_rdata = (!dev_oe_n && (dev_vpp_on || !dev_ce_n)) ? mem[dev_addr] : 8'h00;

   task automatic chk(string req, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
      end
   endtask

   task automatic monitor();
      logic [AW+DW:0] prev = '0;
      logic pce = 1, pvpp = 0, pvcc = 0, poe = 1, pdoe = 0;
      logic [AW-1:0] paddr = '0;
      forever begin
         @(negedge clk);
         // data source: one-cycle-late answer
         if (src_req && !src_vld) begin
            src_vld  = 1;
            src_byte = tgt[src_addr];
            reqs[src_addr]++;
         end else src_vld = 0;
         // stability of address, data and vpp before ce falls (R7)
         if ({dev_addr, dev_wdata, dev_vpp_on} == prev) stab++; else stab = 0;
         prev = {dev_addr, dev_wdata, dev_vpp_on};
         hold_c++; rel_c++;
         if (pce && !dev_ce_n && dev_vpp_on && stab < min_setup) min_setup = stab;
         if (!pce && dev_ce_n) hold_c = 0;
         if (pdoe && !dev_wdata_oe) begin
            if (hold_c < min_hold) min_hold = hold_c;
            rel_c = 0;
         end
         if (poe && !dev_oe_n && dev_vpp_on && rel_c < min_rel) min_rel = rel_c;
         // pulse accounting and cell model
         if (!dev_ce_n && dev_vpp_on) low_len++;
         if (!pce && dev_ce_n && pvpp) begin
            if (low_len == TICK) begin
               icnt[dev_addr]++;
               if (icnt[dev_addr] >= need[dev_addr]) mem[dev_addr] &= dev_wdata;
            end else olen[dev_addr] = low_len;
            low_len = 0;
         end
         if (dev_ce_n) low_len = 0;
         // supply ordering (R6) and address-change rule (R8)
         if (dev_vpp_on && !pvpp && !pvcc) v6++;
         if (!dev_vcc_prog && pvcc && pvpp) v6++;
         if (dev_vpp_on && !dev_vcc_prog) v6++;
         if (dev_addr != paddr && !(poe && dev_oe_n)) v8++;
         if (pvpp && !dev_vpp_on && corrupt_en) mem[corrupt_a] = 8'hFF;
         pce = dev_ce_n; pvpp = dev_vpp_on; pvcc = dev_vcc_prog;
         poe = dev_oe_n; pdoe = dev_wdata_oe; paddr = dev_addr;
      end
   endtask

   task automatic run(int f, int l);
      int cyc;
      for (int i = 0; i < 16; i++) begin icnt[i] = 0; olen[i] = 0; reqs[i] = 0; end
      @(negedge clk);
      first_addr = AW'(f); last_addr = AW'(l); start = 1;
      @(negedge clk);
      start = 0;
      chk("R10 busy after start", int'(busy), 1);
      cyc = 0;
      while (!(done || fail) && cyc < LIM) begin @(negedge clk); cyc++; end
      if (cyc >= LIM) chk("watchdog", 0, 1);
   endtask

   // addr, target, pulses needed
   localparam logic [19:0] VEC [6] = '{
      {4'd0, 8'hA5, 8'd1}, {4'd1, 8'h3C, 8'd2}, {4'd2, 8'h00, 8'd3},
      {4'd3, 8'h7E, 8'd25}, {4'd4, 8'hFF, 8'd1}, {4'd5, 8'h81, 8'd4}
   };

   initial begin
      for (int i = 0; i < 16; i++) begin mem[i] = 8'hFF; tgt[i] = 8'hFF; need[i] = 1; end
      fork monitor(); join_none
      repeat (3) @(negedge clk);
      // R1 reset / idle levels
      chk("R1 ce_n", int'(dev_ce_n), 1);
      chk("R1 oe_n", int'(dev_oe_n), 1);
      chk("R1 drv", int'(dev_wdata_oe), 0);
      chk("R1 vpp", int'(dev_vpp_on), 0);
      chk("R1 vcc", int'(dev_vcc_prog), 0);
      chk("R1 status", int'({busy, done, fail}), 0);
      rst_n = 1;
      repeat (2) @(negedge clk);
      chk("R1 idle after reset", int'({busy, done, fail, dev_ce_n, dev_oe_n}), 3);

      // table walk: main run over addresses 0..5
      for (int k = 0; k < 6; k++) begin
         tgt[VEC[k][19:16]]  = VEC[k][15:8];
         need[VEC[k][19:16]] = int'(VEC[k][7:0]);
      end
      run(0, 5);
      chk("R10 done", int'({done, fail, busy}), 4);
      for (int k = 0; k < 6; k++) begin
         int a;
         a = int'(VEC[k][19:16]);
         chk("R2 R3 short pulses", icnt[a], (VEC[k][15:8] == 8'hFF) ? 1 : need[a]);
         chk("R4 overprogram length", olen[a], 3 * TICK * ((VEC[k][15:8] == 8'hFF) ? 1 : need[a]));
         chk("R9 cell content", int'(mem[a]), int'(VEC[k][15:8]));
         chk("R10 requests per address", reqs[a], 2);
      end
      chk("R6 supplies off at done", int'({dev_vpp_on, dev_vcc_prog}), 0);

      // R5 R11: bit that must return to 1, single address
      mem[8] = 8'h0F; tgt[8] = 8'hF3; need[8] = 1;
      run(8, 8);
      chk("R5 fail flag", int'({fail, done}), 2);
      chk("R5 fail_addr", int'(fail_addr), 8);
      chk("R5 fail_data", int'(fail_data), 8'h03);
      chk("R5 capped pulses", icnt[8], 25);
      chk("R5 no overprogram", olen[8], 0);
      chk("R6 supplies off at fail", int'({dev_vpp_on, dev_vcc_prog}), 0);

      // R5: cell needs more than the cap; next address untouched
      tgt[9] = 8'h5A; need[9] = 26; tgt[10] = 8'h11;
      run(9, 10);
      chk("R5 fail_addr cap", int'(fail_addr), 9);
      chk("R5 fail_data cap", int'(fail_data), 8'hFF);
      chk("R5 pulses at cap", icnt[9], 25);
      chk("R5 later address skipped", reqs[10] + icnt[10], 0);
      chk("R5 later cell erased", int'(mem[10]), 8'hFF);

      // R9: cell lost before the closing read pass
      tgt[11] = 8'h12; need[11] = 1; tgt[12] = 8'h34; need[12] = 2;
      corrupt_en = 1; corrupt_a = 4'd12;
      run(11, 12);
      corrupt_en = 0;
      chk("R9 final fail", int'({fail, done}), 2);
      chk("R9 fail_addr", int'(fail_addr), 12);
      chk("R9 fail_data", int'(fail_data), 8'hFF);
      chk("R9 programmed before", icnt[12], 2);
      chk("R10 re-request", reqs[11], 2);

      // R11: single address passing, and done after an earlier fail
      tgt[13] = 8'h55; need[13] = 5;
      run(13, 13);
      chk("R11 done", int'({done, fail}), 2);
      chk("R11 pulses", icnt[13], 5);
      chk("R11 overprogram", olen[13], 3 * 5 * TICK);
      chk("R11 content", int'(mem[13]), 8'h55);

      // interval and ordering measurements
      chk("R7 setup cycles ok", int'(min_setup >= SETC), 1);
      chk("R7 hold cycles ok", int'(min_hold >= SETC), 1);
      chk("R7 release cycles ok", int'(min_rel >= SETC), 1);
      chk("R6 ordering violations", v6, 0);
      chk("R8 address change violations", v8, 0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule